// File: doc/BRIEF.md
# Packed FP4 Block Dequantizer

This block turns one microscaling block of 4-bit floats into 32 single-precision numbers. The input is a byte stream. The first byte of each block is a shared power-of-two scale, stored with an exponent bias of 127. The next 16 bytes each carry two 4-bit codes. Each code has a sign bit, a 2-bit exponent with bias 1 and a single mantissa bit. Every code stands for a finite value, because the format has no infinity or NaN codes.

The block takes the two codes out of each byte and sends them in order. Each code is decoded to its real value and multiplied by the block scale. The product is presented as an exact IEEE-754 single-precision word on a valid/ready output stream. A flag marks the 32nd result of each block.

Both streams use valid/ready handshakes, so a slow consumer can stall the output with no loss of data. When a block ends, the block returns by itself to waiting for the next scale byte.

Top module: `mx4_block_dequant`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the first byte accepted is taken as the block scale.
- R2: Each data byte gives two results in order: first the code in bits 3:0, then the code in bits 7:4.
- R3: A code with exponent field e ≠ 0, mantissa bit m and sign s gives (−1)^s·(1+m/2)·2^(e−1)·2^(scale−127) as an exact single-precision word.
- R4: Exponent field 0 with mantissa 1 decodes to ±0.5 before scaling. Exponent field 0 with mantissa 0 gives 0x00000000 when the sign bit is clear and 0x80000000 when it is set, for any scale other than 0xFF.
- R5: When the biased result exponent would reach 255 or more, the output is ±infinity: the sign bit, then 0xFF in bits 30:23, then 0 in bits 22:0.
- R6: When the biased result exponent would be 0 or below, the output is the exact single-precision subnormal: exponent bits 0, fraction equal to the value divided by 2^−149.
- R7: A scale byte of 0xFF makes all 32 results of that block 0x7FC00000, whatever the codes are.
- R8: `out_last` is 1 on the 32nd result of a block and 0 on the other results. The byte accepted after that result is taken as a new scale.
- R9: `in_ready` is 0 while a data byte still has a result not yet sent, and 1 otherwise.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Scale byte or packed pair of codes |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Result word is valid |
| out_data | output | 32 | Single-precision result |
| out_last | output | 1 | Result is the last of its block |
| out_ready | input | 1 | Consumer accepts the result |

## Verification
The bench builds the block with its default parameters: 32 elements per block and 0xFF as the NaN scale. With those values, 256 blocks are enough to sweep every scale byte from 0 to 255 together with all 16 codes, each code in both nibble positions. That sweep covers every overflow, subnormal-underflow and NaN-scale case. Both handshakes are throttled by a pseudo-random pattern, so stalls on either side come up many times, including at block boundaries.

// File: rtl/mx4_block_dequant.sv
module mx4_block_dequant #(
  parameter int          ELEMS     = 32,
  parameter logic [7:0]  NAN_SCALE = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        out_last,
  input  logic        out_ready
);
  localparam int CW = $clog2(ELEMS);

  logic          have_scale, byte_full, nib;
  logic [7:0]    scale_q, byte_q;
  logic [CW-1:0] cnt;

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;

  assign in_ready  = !byte_full;
  assign out_valid = byte_full;
  assign out_last  = (cnt == CW'(ELEMS - 1));

  wire [3:0] code = nib ? byte_q[7:4] : byte_q[3:0];
  wire       sgn  = code[3];
  wire [1:0] ef   = code[2:1];
  wire       mf   = code[0];
  wire       frac = (ef != 2'd0) && mf;

  logic signed [9:0] bexp;
  assign bexp = $signed({2'b00, scale_q}) + $signed({8'b0, ef}) - 10'sd1;

  logic [23:0] sig;
  logic [22:0] sub;
  assign sig = {1'b1, frac, 22'b0};
  assign sub = (bexp == 10'sd0) ? sig[23:1] : {1'b0, sig[23:2]};

  always_comb begin
    if (scale_q == NAN_SCALE)
      out_data = 32'h7FC00000;
    else if (ef == 2'd0 && !mf)
      out_data = {sgn, 31'b0};
    else if (bexp >= 10'sd255)
      out_data = {sgn, 8'hFF, 23'b0};
    else if (bexp <= 10'sd0)
      out_data = {sgn, 8'h00, sub};
    else
      out_data = {sgn, bexp[7:0], frac, 22'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_scale <= 1'b0;
      byte_full  <= 1'b0;
      nib        <= 1'b0;
      scale_q    <= 8'h00;
      byte_q     <= 8'h00;
      cnt        <= '0;
    end else begin
      if (take) begin
        if (!have_scale) begin
          scale_q    <= in_data;
          have_scale <= 1'b1;
        end else begin
          byte_q    <= in_data;
          byte_full <= 1'b1;
          nib       <= 1'b0;
        end
      end
      if (give) begin
        nib <= ~nib;
        if (nib) byte_full <= 1'b0;
        if (out_last) begin
          cnt        <= '0;
          have_scale <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module mx4_block_dequant_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_last,
  input logic        out_ready,
  input logic        have_scale,
  input logic [7:0]  scale_q,
  input logic        nib
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R2
  nibble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !nib |=> out_valid && nib);
  // R9
  data_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && have_scale |=> out_valid && !in_ready);
  // R7
  nan_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && scale_q == 8'hFF |-> out_data == 32'h7FC00000);
  // R8
  last_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !have_scale);
  // R5
  inf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && scale_q != 8'hFF && out_data[30:23] == 8'hFF |-> out_data[22:0] == 23'd0);
endmodule

bind mx4_block_dequant mx4_block_dequant_chk u_chk (.*);

// File: tb/mx4_block_dequant_bench.sv
module mx4_block_dequant_bench;
  localparam int NBLK  = 256;
  localparam int NBYTE = NBLK * 17;
  localparam int NOUT  = NBLK * 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  mx4_block_dequant u_mx4_block_dequant (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready));

  logic [7:0]  stream [NBYTE];
  logic [31:0] expv   [NOUT];
  string       etag   [NOUT];
  int checks = 0, fails = 0;

  function automatic logic [31:0] ref_val(input logic [7:0] sc, input logic [3:0] c, output string tag);
    int e, m, v2, p, ex;
    logic [31:0] fld;
    e = int'(c[2:1]); m = int'(c[0]);
    if (sc == 8'hFF) begin tag = "R7"; return 32'h7FC00000; end
    v2 = (e == 0) ? m : ((2 + m) << (e - 1));
    if (v2 == 0) begin tag = "R4"; return {c[3], 31'b0}; end
    p = (v2 >= 8) ? 3 : (v2 >= 4) ? 2 : (v2 >= 2) ? 1 : 0;
    ex = p + int'(sc) - 1;
    if (ex >= 255) begin tag = "R5"; return {c[3], 8'hFF, 23'b0}; end
    if (ex <= 0) begin
      tag = "R6";
      fld = 32'(v2) << (int'(sc) + 21);
      return {c[3], 8'h00, fld[22:0]};
    end
    tag = (e == 0) ? "R4 R2" : "R3 R2";
    fld = (32'(v2) << 23) >> p;
    return {c[3], ex[7:0], fld[22:0]};
  endfunction

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      stream[b*17] = 8'(b);
      for (int k = 0; k < 16; k++) begin
        logic [7:0] d;
        string t;
        d = 8'(b * 16 + k * 17);
        stream[b*17 + 1 + k] = d;
        expv[b*32 + 2*k]     = ref_val(8'(b), d[3:0], t);
        etag[b*32 + 2*k]     = t;
        expv[b*32 + 2*k + 1] = ref_val(8'(b), d[7:4], t);
        etag[b*32 + 2*k + 1] = t;
      end
    end
  end

  initial begin
    int idx, oidx, cyc;
    logic [15:0] lfsr;
    idx = 0; oidx = 0; cyc = 0; lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    while (oidx < NOUT && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      in_valid  = (idx < NBYTE) && (lfsr[5] | lfsr[7]);
      in_data   = (idx < NBYTE) ? stream[idx] : 8'h00;
      #1;
      if (out_valid) begin
        checks++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R9 in_ready=%b expected 0 while result pending", in_ready);
        end
      end
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        checks++;
        if (out_data !== expv[oidx]) begin
          fails++;
          $display("FAIL %s elem %0d: got %h expected %h", etag[oidx], oidx, out_data, expv[oidx]);
        end
        checks++;
        if (out_last !== ((oidx % 32) == 31)) begin
          fails++;
          $display("FAIL R8 elem %0d: out_last=%b expected %b", oidx, out_last, (oidx % 32) == 31);
        end
        oidx++;
      end else if (out_valid && !out_ready) begin
        logic [31:0] hold;
        hold = out_data;
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b1 || out_data !== hold) begin
          fails++;
          $display("FAIL R10 stall: valid=%b data=%h expected 1 %h", out_valid, out_data, hold);
        end
      end
    end
    checks++;
    if (oidx < NOUT) begin
      fails++;
      $display("FAIL watchdog: %0d results expected %0d", oidx, NOUT);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule